// File: doc/BRIEF.md
# FIFO Stall Timeout Detector

This block watches a receive FIFO and a transmit FIFO and raises a "hung" interrupt when either one stays blocked for too long without progress. A shared prescaler turns the core clock into a slow tick. The period of that tick is a fixed base count shifted right by a programmable scale. Each channel has its own counter of those ticks. The counter advances only while its FIFO reports that it is blocked, and any push or pop on that FIFO returns it to zero. When the count reaches a programmable threshold, the channel's raw interrupt bit is set.

Each source has a raw bit, a masked status bit, an enable bit and a write-one-to-clear strobe. A single combined interrupt line is the OR of the masked status bits. A global detection enable gates the prescaler and both counters. The FIFOs themselves, the data movers that feed them and any clock-domain crossing of the configuration sit outside this block. Stall and activity conditions arrive as per-cycle input levels and strobes. The block carries no data stream, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `fifo_stall_watch`

## Requirements
- R1: With `det_enable` high, the tick period is `(BASE_COUNT >> tick_scale) + 1` clock cycles, and the prescaler restarts once its count reaches or exceeds `BASE_COUNT >> tick_scale`. After `det_enable` rises, a channel that stays blocked sets its raw bit on exactly the `stall_threshold * period`-th rising edge.
- R2: A raw bit is not set before its channel's stall count reaches the threshold.
- R3: A one-cycle pulse on `fifo_activity[i]` returns channel i's stall count to zero. Counting then restarts from zero on the following ticks.
- R4: Once a channel's count equals the threshold it holds there. The raw bit is therefore set only once per stall episode, and after it is cleared it stays clear while the FIFO remains blocked.
- R5: A 1 on `irq_clear[i]` clears `irq_raw[i]` on that edge, and the strobe holds no state. When a set condition and a clear occur in the same cycle, the set wins.
- R6: `irq_status = irq_raw & irq_enable`, and `hung_irq` is high exactly when any bit of `irq_status` is high.
- R7: While `det_enable` is low, the prescaler and both stall counters are held at zero and no raw bit is set. Raw bits that are already set keep their value.
- R8: Index 0 of every per-channel vector is the receive channel and index 1 is the transmit channel. A stall on one channel never sets the other channel's raw bit.
- R9: A threshold of 0 never sets a raw bit.
- R10: After reset, `irq_raw`, `irq_status` and `hung_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_enable | input | 1 | Global enable for tick generation and stall counting |
| tick_scale | input | SCALE_W (3) | Right shift applied to the base count to set the tick period |
| stall_threshold | input | THR_W (8) | Number of stalled ticks that raises the interrupt |
| fifo_blocked | input | 2 | Per-channel level: FIFO cannot make progress (0 rx, 1 tx) |
| fifo_activity | input | 2 | Per-channel strobe: a push or pop happened this cycle |
| irq_enable | input | 2 | Per-source interrupt enable |
| irq_clear | input | 2 | Per-source write-one-to-clear strobe |
| irq_raw | output | 2 | Raw hung interrupt bits |
| irq_status | output | 2 | Raw bits masked by the enables |
| hung_irq | output | 1 | OR of all masked status bits |

## Verification
The main function is tried with a table of scale, threshold and channel combinations. Each entry is checked one edge before and exactly on the expected firing edge, which separates an off-by-one tick period from an off-by-one threshold compare and a swap of the channels. Directed patterns follow. An activity pulse in mid-stall tells a counter reset apart from a mere pause. A set coinciding with a clear exposes the wrong priority, and a long stall after a clear catches a counter that does not saturate. Disabled detection and a zero threshold must stay silent, and toggling the enables distinguishes raw from masked status.

// File: rtl/stall_pkg.sv
package stall_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_RX  = 0;
  localparam int CH_TX  = 1;
  localparam int DEFAULT_BASE_COUNT = 88000;
endpackage

// File: rtl/stall_tick_gen.sv
module stall_tick_gen #(
  parameter int BASE_COUNT = 88000,
  parameter int SCALE_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  localparam int CNT_W = $clog2(BASE_COUNT + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(BASE_COUNT) >> scale;
  assign tick  = en && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!en)     cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assert_tick_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));

  assert_idle_prescaler_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

// File: rtl/stall_chan_counter.sv
module stall_chan_counter #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             blocked,
  input  logic             activity,
  input  logic [THR_W-1:0] threshold,
  output logic             hit
);
  logic [THR_W-1:0] cnt;
  logic [THR_W:0]   cnt_inc;
  logic             step;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign step    = en && !activity && blocked && tick && (cnt < threshold);
  assign hit     = step && (cnt_inc == {1'b0, threshold});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!en || activity) cnt <= '0;
    else if (step)           cnt <= cnt_inc[THR_W-1:0];
  end

  assert_activity_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> (cnt == '0));

  assert_disabled_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

  assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !activity && (cnt == threshold)) |=> (cnt == $past(cnt)));

  assert_no_zero_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (threshold == '0) |-> !hit);
endmodule

// File: rtl/stall_irq_bank.sv
module stall_irq_bank #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set,
  input  logic [NUM_SRC-1:0] clear,
  input  logic [NUM_SRC-1:0] enable,
  output logic [NUM_SRC-1:0] raw,
  output logic [NUM_SRC-1:0] status
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       raw[i] <= 1'b0;
      else if (set[i])  raw[i] <= 1'b1;
      else if (clear[i]) raw[i] <= 1'b0;
    end

    assign status[i] = raw[i] & enable[i];

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> raw[i]);

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clear[i] && !set[i]) |=> !raw[i]);

    assert_raw_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[i] && !clear[i]) |=> raw[i]);
  end
endmodule

// File: rtl/fifo_stall_watch.sv
module fifo_stall_watch
  import stall_pkg::*;
#(
  parameter int BASE_COUNT = DEFAULT_BASE_COUNT,
  parameter int SCALE_W    = 3,
  parameter int THR_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               det_enable,
  input  logic [SCALE_W-1:0] tick_scale,
  input  logic [THR_W-1:0]   stall_threshold,
  input  logic [NUM_CH-1:0]  fifo_blocked,
  input  logic [NUM_CH-1:0]  fifo_activity,
  input  logic [NUM_CH-1:0]  irq_enable,
  input  logic [NUM_CH-1:0]  irq_clear,
  output logic [NUM_CH-1:0]  irq_raw,
  output logic [NUM_CH-1:0]  irq_status,
  output logic               hung_irq
);
  logic              tick;
  logic [NUM_CH-1:0] hit;

  stall_tick_gen #(
    .BASE_COUNT (BASE_COUNT),
    .SCALE_W    (SCALE_W)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (det_enable),
    .scale (tick_scale),
    .tick  (tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    stall_chan_counter #(
      .THR_W (THR_W)
    ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (det_enable),
      .tick      (tick),
      .blocked   (fifo_blocked[c]),
      .activity  (fifo_activity[c]),
      .threshold (stall_threshold),
      .hit       (hit[c])
    );
  end

  stall_irq_bank #(
    .NUM_SRC (NUM_CH)
  ) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (hit),
    .clear  (irq_clear),
    .enable (irq_enable),
    .raw    (irq_raw),
    .status (irq_status)
  );

  assign hung_irq = |irq_status;

  assert_line_needs_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hung_irq |-> (|irq_raw));

  assert_no_set_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_enable && !irq_raw[CH_RX] && !irq_raw[CH_TX]) |=> (irq_raw == '0));
endmodule

// File: tb/tb_fifo_stall_watch.sv
module tb_fifo_stall_watch;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam int VEC_SCALE[NV] = '{7, 7, 6, 5, 7};
  localparam int VEC_THR[NV]   = '{1, 3, 2, 1, 5};
  localparam int VEC_CH[NV]    = '{0, 1, 0, 1, 1};
  localparam int VEC_EDGES[NV] = '{688, 2064, 2752, 2751, 3440};
  localparam int P7 = 688;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       det_enable = 0;
  logic [2:0] tick_scale = 3'd7;
  logic [7:0] stall_threshold = 8'd1;
  logic [1:0] fifo_blocked = 0, fifo_activity = 0, irq_enable = 2'b11, irq_clear = 0;
  logic [1:0] irq_raw, irq_status;
  logic       hung_irq;

  int n_tests = 0, n_fail = 0;

  fifo_stall_watch dut (
    .clk(clk), .rst_n(rst_n), .det_enable(det_enable), .tick_scale(tick_scale),
    .stall_threshold(stall_threshold), .fifo_blocked(fifo_blocked),
    .fifo_activity(fifo_activity), .irq_enable(irq_enable), .irq_clear(irq_clear),
    .irq_raw(irq_raw), .irq_status(irq_status), .hung_irq(hung_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic restart();
    det_enable = 0; fifo_blocked = 0; fifo_activity = 0; irq_clear = 2'b11;
    step(1);
    irq_clear = 0; det_enable = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    step(2);
    check("R10 raw", irq_raw, 0);
    check("R10 status", irq_status, 0);
    check("R10 hung", hung_irq, 0);
    rst_n = 1;
    step(1);

    // R1 R2 R8 vector walk
    for (int i = 0; i < NV; i++) begin
      tick_scale = 3'(VEC_SCALE[i]);
      stall_threshold = 8'(VEC_THR[i]);
      restart();
      fifo_blocked = 2'(1 << VEC_CH[i]);
      step(VEC_EDGES[i] - 1);
      check("R2 early edge", irq_raw, 0);
      step(1);
      check("R1 R8 firing edge", irq_raw, 1 << VEC_CH[i]);
    end

    // R5 set wins over a simultaneous clear
    tick_scale = 3'd7; stall_threshold = 8'd1;
    restart();
    fifo_blocked = 2'b01;
    step(P7 - 1);
    irq_clear = 2'b01;
    step(1);
    irq_clear = 0;
    check("R5 set beats clear", irq_raw, 1);
    irq_clear = 2'b01;
    step(1);
    irq_clear = 0;
    check("R5 clear", irq_raw, 0);
    // R4 saturation: no second fire while still blocked
    step(3 * P7);
    check("R4 single fire", irq_raw, 0);

    // R6 masking
    restart();
    fifo_blocked = 2'b10;
    step(P7);
    check("R6 raw tx", irq_raw, 2);
    irq_enable = 2'b00; #1;
    check("R6 status masked", irq_status, 0);
    check("R6 hung masked", hung_irq, 0);
    irq_enable = 2'b10; #1;
    check("R6 status on", irq_status, 2);
    check("R6 hung on", hung_irq, 1);
    irq_enable = 2'b01; #1;
    check("R6 other enable", irq_status, 0);
    irq_enable = 2'b11;

    // R3 activity resets the stall count
    stall_threshold = 8'd2;
    restart();
    fifo_blocked = 2'b01;
    step(P7 + 10);
    fifo_activity = 2'b01;
    step(1);
    fifo_activity = 0;
    step(2 * P7 - 12);
    check("R3 delayed by activity", irq_raw, 0);
    step(1);
    check("R3 fires after recount", irq_raw, 1);

    // R7 raw held while disabled, then no detection while disabled
    det_enable = 0;
    step(5);
    check("R7 raw held", irq_raw, 1);
    restart();
    det_enable = 0; fifo_blocked = 2'b11;
    step(3 * P7);
    check("R7 disabled silent", irq_raw, 0);

    // R9 zero threshold
    stall_threshold = 8'd0;
    restart();
    fifo_blocked = 2'b11;
    step(3 * P7);
    check("R9 zero threshold", irq_raw, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule